// File: doc/BRIEF.md
# Always-On Millisecond Time Counter with Coherent Seconds Snapshot

This block keeps wall time on a slow clock that stays alive through low-power states. A fractional divider turns the slow input clock into a stream of millisecond ticks. A millisecond counter runs from zero to one below the per-second count and then wraps. On each wrap a seconds counter advances, and the seconds counter itself rolls over to zero when it reaches its full width.

Software reads the time through a small register read port with one cycle of latency. Time is kept as a seconds value and a milliseconds value. Software cannot read both in one access, so every read of the milliseconds register also copies the live seconds value into a shadow register. Software reads milliseconds first and then the shadow seconds register. The pair it gets back is coherent, and the full time in milliseconds is shadow seconds times 1000 plus milliseconds.

The read port is a two-state machine. RD_IDLE means no read data is pending. RD_REPLY means the previous cycle accepted a read, so the read data is valid now. The transitions are named as follows:
- accept: RD_IDLE to RD_REPLY when `rd_en` is high.
- chain: RD_REPLY stays in RD_REPLY when `rd_en` is high again.
- release: RD_REPLY to RD_IDLE when `rd_en` is low.
- stay: RD_IDLE remains in RD_IDLE when `rd_en` is low.

Top module: `rtc_shadow_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rd_valid` is 0, `rd_data` is 0, and the millisecond, seconds and shadow registers all hold 0.
- R2: After n rising edges of `clk_rtc` with `rst_n` high, the number of millisecond ticks taken is floor(n * TICK_HZ / CLK_HZ).
- R3: The millisecond count stays between 0 and MS_PER_SEC-1. A tick at MS_PER_SEC-1 sets it back to 0 and adds one to seconds, and seconds changes at no other time.
- R4: Seconds is a SEC_W-bit count that wraps from all ones to zero.
- R5: A read with `rd_addr` = 0x08 returns the live seconds value, zero-extended to DATA_W. The value is the one held at the edge that accepted the read.
- R6: A read with `rd_addr` = 0x10 returns the milliseconds value. At the same edge it loads the shadow register with the live seconds value.
- R7: A read with `rd_addr` = 0x0c returns the shadow register. The shadow register changes only on a read of 0x10, so reads of other offsets and the passing of time leave it unchanged.
- R8: A read of any offset other than 0x08, 0x0c and 0x10 returns zero.
- R9: `rd_valid` is high in exactly the cycle after each cycle in which `rd_en` was high, and low otherwise. Back-to-back reads are accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request, one access per cycle |
| rd_addr | input | ADDR_W | Byte offset of the register to read |
| rd_data | output | DATA_W | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | Read data valid, one cycle after the request |

## Verification
The bench builds the block with CLK_HZ=10, TICK_HZ=4, MS_PER_SEC=5 and SEC_W=4. The ratio 4/10 is not a whole number, so the accumulating divider is exercised and its tick spacing varies from cycle to cycle. Seconds advance every dozen or so cycles, which lets the bench watch the shadow register hold still while live seconds move. The 4-bit seconds count wraps after about 200 cycles, so the rollover is reached within a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    // Register offsets; software relies on these exact byte addresses.
    localparam int OFF_SEC    = 'h08;
    localparam int OFF_SHADOW = 'h0C;
    localparam int OFF_MS     = 'h10;

    typedef enum logic {
        RD_IDLE,
        RD_REPLY
    } rd_state_e;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int CLK_HZ  = 32768,
    parameter int TICK_HZ = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_HZ % TICK_HZ == 0) begin : g_integer
            localparam int DIV   = CLK_HZ / TICK_HZ;
            localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            assign tick = (cnt_q == LAST);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    cnt_q <= '0;
                else if (tick) cnt_q <= '0;
                else           cnt_q <= cnt_q + 1'b1;
            end
        end else begin : g_fraction
            localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;
            localparam logic [ACC_W-1:0] INC = ACC_W'(TICK_HZ);
            localparam logic [ACC_W-1:0] MOD = ACC_W'(CLK_HZ);
            logic [ACC_W-1:0] acc_q;
            logic [ACC_W-1:0] sum;

            assign sum  = acc_q + INC;
            assign tick = (sum >= MOD);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    acc_q <= '0;
                else if (tick) acc_q <= sum - MOD;
                else           acc_q <= sum;
            end
        end
    endgenerate
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt #(
    parameter int MS_PER_SEC = 1000,
    parameter int SEC_W      = 32,
    localparam int MS_W      = $clog2(MS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [MS_W-1:0]  ms_q,
    output logic [SEC_W-1:0] sec_q
);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    logic ms_wrap;
    assign ms_wrap = tick && (ms_q == MS_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ms_q <= '0;
        else if (ms_wrap) ms_q <= '0;
        else if (tick)    ms_q <= ms_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sec_q <= '0;
        else if (ms_wrap) sec_q <= sec_q + 1'b1;
    end
endmodule

// File: rtl/rtc_rd_port.sv
module rtc_rd_port
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int MS_W   = 10,
    parameter int SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [MS_W-1:0]   ms_q,
    input  logic [SEC_W-1:0]  sec_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [SEC_W-1:0]  shadow_q
);
    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] sel_data;
    logic              hit_ms;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, stay, chain, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  state_d = rd_en ? RD_REPLY : RD_IDLE;
            RD_REPLY: state_d = rd_en ? RD_REPLY : RD_IDLE;
        endcase
    end

    assign rd_valid = (state_q == RD_REPLY);
    assign hit_ms   = (rd_addr == ADDR_W'(OFF_MS));

    always_comb begin
        if (hit_ms)                               sel_data = DATA_W'(ms_q);
        else if (rd_addr == ADDR_W'(OFF_SEC))     sel_data = DATA_W'(sec_q);
        else if (rd_addr == ADDR_W'(OFF_SHADOW))  sel_data = DATA_W'(shadow_q);
        else                                      sel_data = '0;
    end

    // Output and snapshot registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            shadow_q <= '0;
        end else if (rd_en) begin
            rd_data <= sel_data;
            if (hit_ms) shadow_q <= sec_q;
        end
    end
endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top #(
    parameter int CLK_HZ     = 32768,
    parameter int TICK_HZ    = 1000,
    parameter int MS_PER_SEC = 1000,
    parameter int SEC_W      = 32,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic              clk_rtc,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int MS_W = $clog2(MS_PER_SEC);

    logic             ms_tick;
    logic [MS_W-1:0]  ms_cnt;
    logic [SEC_W-1:0] sec_cnt;
    logic [SEC_W-1:0] shadow_sec;

    rtc_tick_div #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_div (
        .clk   (clk_rtc),
        .rst_n (rst_n),
        .tick  (ms_tick)
    );

    rtc_time_cnt #(.MS_PER_SEC(MS_PER_SEC), .SEC_W(SEC_W)) u_cnt (
        .clk   (clk_rtc),
        .rst_n (rst_n),
        .tick  (ms_tick),
        .ms_q  (ms_cnt),
        .sec_q (sec_cnt)
    );

    rtc_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MS_W(MS_W), .SEC_W(SEC_W)) u_rd (
        .clk      (clk_rtc),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .ms_q     (ms_cnt),
        .sec_q    (sec_cnt),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .shadow_q (shadow_sec)
    );
endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
    import rtc_pkg::*;
#(
    parameter int MS_PER_SEC = 1000,
    parameter int SEC_W      = 32,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    localparam int MS_W      = $clog2(MS_PER_SEC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [MS_W-1:0]   ms_q,
    input logic [SEC_W-1:0]  sec_q,
    input logic [SEC_W-1:0]  shadow_q
);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    logic ms_rd, known_rd;
    assign ms_rd    = rd_en && (rd_addr == ADDR_W'(OFF_MS));
    assign known_rd = ms_rd || (rd_addr == ADDR_W'(OFF_SEC)) || (rd_addr == ADDR_W'(OFF_SHADOW));

    assert_ms_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q <= MS_LAST);

    assert_ms_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ms_q == $past(ms_q)) || (ms_q == MS_W'($past(ms_q) + 1'b1))
                 || (ms_q == '0 && $past(ms_q) == MS_LAST));

    assert_sec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sec_q == $past(sec_q))
                 || (sec_q == SEC_W'($past(sec_q) + 1'b1) && $past(ms_q) == MS_LAST && ms_q == '0));

    assert_shadow_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ms_rd |=> shadow_q == $past(sec_q));

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_rd |=> $stable(shadow_q));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !known_rd) |=> rd_data == '0);

    assert_valid_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

bind rtc_shadow_top rtc_shadow_chk #(
    .MS_PER_SEC (MS_PER_SEC),
    .SEC_W      (SEC_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
) u_chk (
    .clk      (clk_rtc),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .ms_q     (ms_cnt),
    .sec_q    (sec_cnt),
    .shadow_q (shadow_sec)
);

// File: tb/rtc_shadow_top_tb.sv
module rtc_shadow_top_tb;
    localparam int CLK_HZ = 10;
    localparam int TICK_HZ = 4;
    localparam int MSPS = 5;
    localparam int SEC_W = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    int n_edges = 0;
    int checks = 0;
    int fails = 0;
    logic [31:0] shadow_exp = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    rtc_shadow_top #(
        .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .MS_PER_SEC(MSPS),
        .SEC_W(SEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dut (
        .clk_rtc(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always @(posedge clk) begin
        if (rst_n) n_edges <= n_edges + 1;
        else       n_edges <= 0;
    end

    function automatic int ticks_at(input int n);
        return (n * TICK_HZ) / CLK_HZ;
    endfunction
    function automatic logic [31:0] ms_at(input int n);
        return 32'(ticks_at(n) % MSPS);
    endfunction
    function automatic logic [31:0] sec_at(input int n);
        return 32'((ticks_at(n) / MSPS) % (1 << SEC_W));
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one request per call, back-to-back when called in a row.
    task automatic do_read(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        case (a)
            8'h08:   e = sec_at(n_edges);
            8'h0C:   e = shadow_exp;
            8'h10: begin
                e = ms_at(n_edges);
                shadow_exp = sec_at(n_edges);
            end
            default: e = '0;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en   = 1'b1;
        rd_addr = a;
    endtask

    task automatic idle(input int k);
        @(negedge clk);
        rd_en = 1'b0;
        repeat (k) @(negedge clk);
    endtask

    // Monitor: pops expected items as results appear (R9 one-cycle latency).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected rd_valid", 32'(rd_valid), 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    initial begin
        #(8 * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid in reset", 32'(rd_valid), 32'd0);
        check(rd_data == '0, "R1 rd_data in reset", rd_data, 32'd0);
        rst_n = 1'b1;
        check(rd_valid == 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        // R1: registers read as zero straight after reset
        do_read(8'h0C, "R1 shadow");
        do_read(8'h08, "R1 sec");
        do_read(8'h10, "R1 ms");
        idle(2);
        check(rd_valid == 1'b0, "R9 rd_valid low when idle", 32'(rd_valid), 32'd0);
        idle(13);
        // R6: ms read then shadow read gives a coherent pair
        do_read(8'h10, "R6 ms");
        do_read(8'h0C, "R6 shadow after ms read");
        idle(2);
        // R8: unmapped offsets
        do_read(8'h04, "R8 offset 0x04");
        do_read(8'h14, "R8 offset 0x14");
        do_read(8'hFF, "R8 offset 0xff");
        do_read(8'h0D, "R8 offset 0x0d");
        idle(30);
        // R7: shadow holds while live seconds advance and other reads occur
        do_read(8'h0C, "R7 shadow held");
        do_read(8'h08, "R5 live sec");
        do_read(8'h0C, "R7 shadow held after sec read");
        idle(3);
        // R2/R3/R5 across many phases of the fractional divider
        for (int i = 0; i < 40; i++) begin
            do_read(8'h10, (n_edges >= 200) ? "R4 ms after wrap" : "R2 ms");
            do_read(8'h0C, "R3 shadow sec");
            do_read(8'h08, "R5 live sec");
            idle(i % 5 + 1);
        end
        // R4: seconds wrapped to zero at 2^SEC_W
        while (n_edges < 205) @(negedge clk);
        do_read(8'h08, "R4 sec wrap");
        do_read(8'h10, "R4 ms");
        do_read(8'h0C, "R4 shadow");
        idle(4);
        check(exp_q.size() == 0, "R9 missing replies", 32'(exp_q.size()), 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule